// File: doc/BRIEF.md
# Standby and Oscillation-Wait Controller

This block holds a byte-wide standby control register and a four-state machine that governs low-power entry and exit. Software writes the register to request sleep or stop, to choose whether pins float during stop, to halt either oscillator while stopped, and to ask for a software reset. A wake-up event ends sleep at once. It ends stop through a stabilization wait, during which the core clock stays gated.

The wait length is counted on a timebase counter that advances at half the clock rate. A two-bit selection picks one of four power-of-two lengths, and each exponent is a parameter, so a bench can shrink them. Three reset causes are handled: the external init pin (asynchronous, active low), a watchdog pulse and a software-reset pulse. Each leaves its own mix of register fields and starts a stabilization wait. After an init-pin reset the wait is always the shortest.

States: `ST_RUN` (core clocked), `ST_SLEEP` (core halted, no wait on exit), `ST_STOP` (oscillators optionally halted, pins held or floated) and `ST_WAIT` (stabilization count). Transitions: RUN→STOP when the stop bit is set, which takes priority. RUN→SLEEP when only the sleep bit is set. SLEEP→RUN on wake. STOP→WAIT on wake. WAIT→RUN when the count completes. Any state→WAIT on a watchdog or software reset. The init pin forces WAIT.

Top module: `stby_osc_ctrl`

## Requirements
- R1: While the init pin is low and just after it is released, rd_data reads 0x33, mode reads 2'b11 (wait) and clk_ready is 0.
- R2: After init-pin release the block stays in wait (mode 2'b11) for exactly 2^(EXP0+1) clocks, whatever wait code was programmed before that reset.
- R3: A write with bit7 = 1 puts the block in stop (mode 2'b10) on the clock after the write. This holds even when bit6 is also 1.
- R4: A write with bit6 = 1 and bit7 = 0 enters sleep (mode 2'b01). A wake pulse returns the block to run (mode 2'b00) on the next clock with no wait, and bit6 reads 0. Wake in run has no effect.
- R5: A wake pulse in stop clears bits 7:6 and enters wait for exactly 2^(EXPk+1) clocks, where k is the code in bits3:2. The block then returns to run.
- R6: hiz_en is 1 only in stop with bit5 = 1. In stop with bit5 = 0, and in all other states, it is 0.
- R7: In stop, main_osc_en = !bit0 and sub_osc_en = !bit1. Outside stop, both are 1.
- R8: A write with bit4 = 0 raises sw_rst_req for exactly one clock, on the clock after the write. Bit4 always reads 1.
- R9: A watchdog pulse sets the register to {2'b00, 1, 1, prior bits3:2, 2'b11} and starts a wait of 2^(EXPk+1) clocks using the prior code k.
- R10: A software-reset pulse clears bits 7:6 and keeps bits 5 and 3:0. It then starts a wait that uses the kept code.
- R11: A register write that arrives while the block is in wait changes no field and does not shorten or end the wait.
- R12: clk_ready is 1 in run and 0 in sleep, stop and wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_init_n | input | 1 | Init-pin reset, asynchronous, active low |
| wdt_rst | input | 1 | Watchdog reset pulse |
| sw_rst | input | 1 | Software reset pulse |
| wake | input | 1 | Wake-up event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| mode | output | 2 | 00 run, 01 sleep, 10 stop, 11 wait |
| hiz_en | output | 1 | Float pin outputs |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| sw_rst_req | output | 1 | One-clock software reset request |
| clk_ready | output | 1 | Core clock released |

## Verification
The bench sweeps all four wait codes through three paths: stop exit, watchdog reset and software reset. It counts wait cycles exactly, so an off-by-one in the terminal count, a counter that is not cleared at entry, or a code taken from the wrong source gives a wrong length. It programs the longest code and then pulses the init pin, which exposes a design that reuses the programmed code there. All eight combinations of the float and oscillator-halt bits are checked both before and during stop, which catches outputs that leak into run. A write during wait and a double stop/sleep request test the lock and the priority. A design that gets these wrong leaves stop early or lands in sleep.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_STOP  = 2'b10,
        ST_WAIT  = 2'b11
    } stby_state_e;

    typedef struct packed {
        logic       stop;
        logic       sleep;
        logic       hiz;
        logic [1:0] wsel;
        logic       sub_halt;
        logic       main_halt;
    } stby_cfg_t;

    localparam int unsigned BIT_STOP  = 7;
    localparam int unsigned BIT_SLEEP = 6;
    localparam int unsigned BIT_HIZ   = 5;
    localparam int unsigned BIT_NSRST = 4;
    localparam int unsigned BIT_WSHI  = 3;
    localparam int unsigned BIT_WSLO  = 2;
    localparam int unsigned BIT_SUBH  = 1;
    localparam int unsigned BIT_MAINH = 0;

endpackage

// File: rtl/stby_cfg_reg.sv
module stby_cfg_reg
    import stby_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wdt_rst,
    input  logic            sw_rst,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic            wr_lock,
    input  logic            clr_req,
    output stby_cfg_t       cfg,
    output logic [7:0]      rd_data,
    output logic            sw_rst_req
);

    logic wr_ok;
    assign wr_ok = wr_en && !wr_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg        <= '{stop: 1'b0, sleep: 1'b0, hiz: 1'b1, wsel: 2'b00,
                            sub_halt: 1'b1, main_halt: 1'b1};
            sw_rst_req <= 1'b0;
        end else begin
            sw_rst_req <= 1'b0;
            if (wdt_rst) begin
                cfg.stop      <= 1'b0;
                cfg.sleep     <= 1'b0;
                cfg.hiz       <= 1'b1;
                cfg.sub_halt  <= 1'b1;
                cfg.main_halt <= 1'b1;
            end else if (sw_rst) begin
                cfg.stop  <= 1'b0;
                cfg.sleep <= 1'b0;
            end else if (clr_req) begin
                cfg.stop  <= 1'b0;
                cfg.sleep <= 1'b0;
            end else if (wr_ok) begin
                cfg.stop      <= wr_data[BIT_STOP];
                cfg.sleep     <= wr_data[BIT_SLEEP];
                cfg.hiz       <= wr_data[BIT_HIZ];
                cfg.wsel      <= wr_data[BIT_WSHI:BIT_WSLO];
                cfg.sub_halt  <= wr_data[BIT_SUBH];
                cfg.main_halt <= wr_data[BIT_MAINH];
                sw_rst_req    <= !wr_data[BIT_NSRST];
            end
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[BIT_STOP]          = cfg.stop;
        rd_data[BIT_SLEEP]         = cfg.sleep;
        rd_data[BIT_HIZ]           = cfg.hiz;
        rd_data[BIT_NSRST]         = 1'b1;
        rd_data[BIT_WSHI:BIT_WSLO] = cfg.wsel;
        rd_data[BIT_SUBH]          = cfg.sub_halt;
        rd_data[BIT_MAINH]         = cfg.main_halt;
    end

    AST_SWREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_req |=> !sw_rst_req) else $error("sw_rst_req wider than one clock"); // R8

    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lock && !wdt_rst && !sw_rst && !clr_req) |=> $stable(cfg))
        else $error("write changed register during wait"); // R11

endmodule

// File: rtl/stby_wait_timer.sv
module stby_wait_timer #(
    parameter int unsigned EXP0 = 1,
    parameter int unsigned EXP1 = 11,
    parameter int unsigned EXP2 = 16,
    parameter int unsigned EXP3 = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       run,
    input  logic [1:0] code,
    output logic       done
);

    localparam int unsigned TB_W = EXP3 + 2;
    localparam logic [TB_W-1:0] LIM0 = TB_W'((64'd1 << (EXP0 + 1)) - 64'd1);
    localparam logic [TB_W-1:0] LIM1 = TB_W'((64'd1 << (EXP1 + 1)) - 64'd1);
    localparam logic [TB_W-1:0] LIM2 = TB_W'((64'd1 << (EXP2 + 1)) - 64'd1);
    localparam logic [TB_W-1:0] LIM3 = TB_W'((64'd1 << (EXP3 + 1)) - 64'd1);

    logic [TB_W-1:0] tb_cnt;
    logic [TB_W-1:0] lim;

    always_comb begin
        unique case (code)
            2'b00:   lim = LIM0;
            2'b01:   lim = LIM1;
            2'b10:   lim = LIM2;
            default: lim = LIM3;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tb_cnt <= '0;
        else if (start)  tb_cnt <= '0;
        else if (run)    tb_cnt <= tb_cnt + 1'b1;
    end

    assign done = run && !start && (tb_cnt == lim);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |-> (tb_cnt <= lim)) else $error("timebase passed limit"); // R5

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wdt_rst,
    input  logic        sw_rst,
    input  logic        wake,
    input  logic        stop_req,
    input  logic        sleep_req,
    input  logic [1:0]  wsel,
    input  logic        wait_done,
    output stby_state_e state,
    output logic [1:0]  wait_code,
    output logic        wait_start,
    output logic        clr_req
);

    stby_state_e nxt;
    logic        rst_evt;

    assign rst_evt = wdt_rst || sw_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_WAIT;
            wait_code <= 2'b00;
        end else begin
            state <= nxt;
            if (wait_start) wait_code <= wsel;
        end
    end

    always_comb begin
        nxt        = state;
        wait_start = 1'b0;
        clr_req    = 1'b0;
        if (rst_evt) begin
            nxt        = ST_WAIT;
            wait_start = 1'b1;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (stop_req)       nxt = ST_STOP;
                    else if (sleep_req) nxt = ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (wake) begin
                        nxt     = ST_RUN;
                        clr_req = 1'b1;
                    end
                end
                ST_STOP: begin
                    if (wake) begin
                        nxt        = ST_WAIT;
                        clr_req    = 1'b1;
                        wait_start = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (wait_done) nxt = ST_RUN;
                end
                default: nxt = ST_WAIT;
            endcase
        end
    end

    AST_STOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && !rst_evt) |=> (state == ST_STOP))
        else $error("stop request did not win"); // R3

    AST_SLEEP_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake && !rst_evt) |=> (state == ST_RUN))
        else $error("sleep exit not immediate"); // R4

    AST_STOP_EXIT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && wake && !rst_evt) |=> (state == ST_WAIT))
        else $error("stop exit skipped wait"); // R5

    AST_RESET_WAIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (state == ST_WAIT && wait_code == $past(wsel)))
        else $error("reset wait not using kept code"); // R9

endmodule

// File: rtl/stby_osc_ctrl.sv
module stby_osc_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned EXP0 = 1,
    parameter int unsigned EXP1 = 11,
    parameter int unsigned EXP2 = 16,
    parameter int unsigned EXP3 = 22
) (
    input  logic       clk,
    input  logic       rst_init_n,
    input  logic       wdt_rst,
    input  logic       sw_rst,
    input  logic       wake,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [1:0] mode,
    output logic       hiz_en,
    output logic       main_osc_en,
    output logic       sub_osc_en,
    output logic       sw_rst_req,
    output logic       clk_ready
);

    stby_cfg_t   cfg;
    stby_state_e state;
    logic [1:0]  wait_code;
    logic        wait_start;
    logic        wait_done;
    logic        clr_req;
    logic        in_stop;

    stby_cfg_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_init_n),
        .wdt_rst    (wdt_rst),
        .sw_rst     (sw_rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_lock    (state == ST_WAIT),
        .clr_req    (clr_req),
        .cfg        (cfg),
        .rd_data    (rd_data),
        .sw_rst_req (sw_rst_req)
    );

    stby_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_init_n),
        .wdt_rst    (wdt_rst),
        .sw_rst     (sw_rst),
        .wake       (wake),
        .stop_req   (cfg.stop),
        .sleep_req  (cfg.sleep),
        .wsel       (cfg.wsel),
        .wait_done  (wait_done),
        .state      (state),
        .wait_code  (wait_code),
        .wait_start (wait_start),
        .clr_req    (clr_req)
    );

    stby_wait_timer #(
        .EXP0 (EXP0),
        .EXP1 (EXP1),
        .EXP2 (EXP2),
        .EXP3 (EXP3)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_init_n),
        .start (wait_start),
        .run   (state == ST_WAIT),
        .code  (wait_code),
        .done  (wait_done)
    );

    assign in_stop     = (state == ST_STOP);
    assign mode        = state;
    assign hiz_en      = in_stop && cfg.hiz;
    assign main_osc_en = !(in_stop && cfg.main_halt);
    assign sub_osc_en  = !(in_stop && cfg.sub_halt);
    assign clk_ready   = (state == ST_RUN);

    AST_HIZ_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rst_init_n)
        hiz_en |-> (mode == 2'b10)) else $error("pins floated outside stop"); // R6

    AST_OSC_ON_OUTSIDE_STOP: assert property (@(posedge clk) disable iff (!rst_init_n)
        (mode != 2'b10) |-> (main_osc_en && sub_osc_en))
        else $error("oscillator halted outside stop"); // R7

    AST_READY_NOT_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_init_n)
        (mode == 2'b11) |-> !clk_ready) else $error("clock released during wait"); // R12

endmodule

// File: tb/sim_stby_osc_ctrl.sv
module sim_stby_osc_ctrl;

    localparam int E0 = 1, E1 = 2, E2 = 3, E3 = 4;

    logic       clk = 1'b0;
    logic       rst_init_n = 1'b0;
    logic       wdt_rst = 1'b0, sw_rst = 1'b0, wake = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [1:0] mode;
    logic       hiz_en, main_osc_en, sub_osc_en, sw_rst_req, clk_ready;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    stby_osc_ctrl #(.EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3)) u0 (
        .clk(clk), .rst_init_n(rst_init_n), .wdt_rst(wdt_rst), .sw_rst(sw_rst),
        .wake(wake), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .mode(mode), .hiz_en(hiz_en), .main_osc_en(main_osc_en),
        .sub_osc_en(sub_osc_en), .sw_rst_req(sw_rst_req), .clk_ready(clk_ready)
    );

    function automatic int wait_len(input int code);
        int e;
        case (code)
            0: e = E0;
            1: e = E1;
            2: e = E2;
            default: e = E3;
        endcase
        return 1 << (e + 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1; @(negedge clk); wake = 1'b0;
    endtask

    task automatic pulse_wdt();
        wdt_rst = 1'b1; @(negedge clk); wdt_rst = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    endtask

    task automatic measure_wait(output int n);
        n = 0;
        while (mode == 2'b11 && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 8'h33);
        check("R1 reset mode", mode, 2'b11);
        check("R12 reset clk_ready", clk_ready, 0);
        check("R8 reset sw_rst_req", sw_rst_req, 0);
        rst_init_n = 1'b1;
        check("R1 release rd_data", rd_data, 8'h33);
        measure_wait(n);
        check("R2 init wait length", n, wait_len(0));
        check("R12 ready in run", clk_ready, 1);
        check("R2 run after wait", mode, 2'b00);

        // R2: programmed longest code, then init pin again
        do_write(8'h1C);
        rst_init_n = 1'b0; @(negedge clk);
        rst_init_n = 1'b1;
        check("R2 rd after re-init", rd_data, 8'h33);
        measure_wait(n);
        check("R2 init ignores programmed code", n, wait_len(0));

        // R3/R5: stop exit sweep over every code
        for (int c = 0; c < 4; c++) begin
            do_write(8'h90 | 8'(c << 2));
            @(negedge clk);
            check("R3 stop entered", mode, 2'b10);
            check("R12 not ready in stop", clk_ready, 0);
            pulse_wake();
            check("R5 stop bit cleared", rd_data[7], 0);
            measure_wait(n);
            check("R5 stop exit wait length", n, wait_len(c));
            check("R5 back to run", mode, 2'b00);
        end

        // R3: stop and sleep together
        do_write(8'hD0);
        @(negedge clk);
        check("R3 stop beats sleep", mode, 2'b10);
        pulse_wake();
        check("R5 both bits cleared", rd_data[7:6], 0);
        measure_wait(n);

        // R4: sleep entry and immediate exit; wake in run ignored
        pulse_wake();
        check("R4 wake in run ignored", mode, 2'b00);
        do_write(8'h50);
        @(negedge clk);
        check("R4 sleep entered", mode, 2'b01);
        check("R12 not ready in sleep", clk_ready, 0);
        pulse_wake();
        check("R4 sleep exit to run", mode, 2'b00);
        check("R4 sleep bit cleared", rd_data[6], 0);

        // R6/R7: pin and oscillator sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] d;
            d = 8'h90 | (i[2] ? 8'h20 : 8'h00) | 8'(i[1:0]);
            do_write(d);
            check("R6 no float before stop", hiz_en, 0);
            check("R7 osc on before stop", {main_osc_en, sub_osc_en}, 2'b11);
            @(negedge clk);
            check("R6 float in stop", hiz_en, i[2]);
            check("R7 main osc in stop", main_osc_en, !i[0]);
            check("R7 sub osc in stop", sub_osc_en, !i[1]);
            pulse_wake();
            check("R7 osc on in wait", {main_osc_en, sub_osc_en}, 2'b11);
            check("R6 no float in wait", hiz_en, 0);
            measure_wait(n);
        end

        // R8: software reset request
        do_write(8'h03);
        check("R8 request pulse", sw_rst_req, 1);
        check("R8 bit4 reads 1", rd_data, 8'h13);
        @(negedge clk);
        check("R8 request one clock", sw_rst_req, 0);
        do_write(8'h10);
        check("R8 no request on bit4=1", sw_rst_req, 0);

        // R9: watchdog sweep
        for (int c = 0; c < 4; c++) begin
            do_write(8'h10 | 8'(c << 2));
            pulse_wdt();
            check("R9 wdt register", rd_data, 8'h33 | 8'(c << 2));
            check("R9 wdt in wait", mode, 2'b11);
            measure_wait(n);
            check("R9 wdt wait length", n, wait_len(c));
        end

        // R10: software reset input sweep, taken from sleep
        for (int c = 0; c < 4; c++) begin
            logic [7:0] d;
            d = 8'h50 | ((c & 1) ? 8'h20 : 8'h00) | 8'(c << 2) | 8'(3 - c);
            do_write(d);
            @(negedge clk);
            pulse_sw();
            check("R10 sw reset register", rd_data, 32'(d & 8'h3F));
            measure_wait(n);
            check("R10 sw reset wait length", n, wait_len(c));
        end

        // R11: write during wait ignored
        do_write(8'h18);
        pulse_wdt();
        do_write(8'hE7);
        check("R11 write in wait ignored", rd_data, 8'h3B);
        measure_wait(n);
        check("R11 wait not cut short", n, wait_len(2) - 1);
        check("R11 run after wait, no stop", mode, 2'b00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule